// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block keeps several small write-back caches coherent over one shared bus. Each cache has its own controller. The controller holds a direct-mapped tag array and a state for every line: invalid, shared or modified. A processor request that the line state can satisfy finishes locally. Any other request first wins the bus, then broadcasts one transaction carrying a block address.

Every other controller compares each bus address with its own tags. An upgrade or a read-for-ownership removes the matching copy. A plain read of a block held modified makes the holder hand the block over, refresh memory with it and fall back to shared. A dirty victim is written back as a separate bus transaction before its line is refilled.

A round-robin arbiter lets exactly one transaction use the bus in a cycle, and every transaction finishes in that one cycle. A word-addressed main memory completes the system.

Top module: `coh_bus_sys`

## Requirements
- R1: After reset no cache signals completion and every line is invalid. Main memory word at address `a` holds `a XOR 0xA5`, truncated to the data width.
- R2: A read to a block present as shared or modified completes with `cpu_hit`=1 and the stored word, without using the bus.
- R3: A read miss fetches the whole block and returns the latest written value. When another cache holds the block modified, that cache supplies it, memory takes the same data, and both copies end shared.
- R4: A write to a block held shared first wins the bus and broadcasts an upgrade that invalidates every other copy. It then completes with `cpu_hit`=0.
- R5: A write to a block held modified completes locally with `cpu_hit`=1.
- R6: Invalidation covers the whole block. After another cache writes any word of a block, a read of a different word of that block misses (`cpu_hit`=0).
- R7: A write miss issues a read-for-ownership. That transaction removes all other copies, including a modified one whose data is merged under the new word.
- R8: A miss whose victim line is modified under a different tag first writes the victim back to memory, so a later miss on the victim reads the written value.
- R9: Arbitration is round-robin: when both caches request in the same cycle, the cache not granted most recently goes first. At most one transaction is on the bus per cycle, and at most one cache supplies data.
- R10: `cpu_done` is a one-cycle pulse per request. The processor holds its request until it sees the pulse.
- R11: When two caches write different words of one shared block in the same cycle, both writes survive. Every later read returns the most recent completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | NC | Per-cache request, held until done |
| cpu_we | input | NC | Per-cache write enable (1 = write) |
| cpu_addr | input | NC*AW | Per-cache word address: {tag, index, word offset} |
| cpu_wdata | input | NC*DW | Per-cache write data |
| cpu_done | output | NC | Per-cache completion pulse |
| cpu_hit | output | NC | Valid with done: 1 when the request completed without the bus |
| cpu_rdata | output | NC*DW | Valid with done: read word (the written word for writes) |

## Verification
The hardest situation to reach is a lost upgrade race. Both caches hold one block shared and ask for the bus in the same cycle to write different words. The loser is invalidated while it waits, so it must turn its pending upgrade into a read-for-ownership. The stimulus first brings the block into both caches with two reads. It then sets the round-robin pointer with a single transaction so the winner is known in advance, and finally starts both writes at the same clock edge. Cross reads afterwards show whether both words survived.

// File: rtl/coh_pkg.sv
package coh_pkg;
   // Line state encoding: 00 invalid, 01 shared, 10 modified
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_MOD = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      BOP_RD  = 2'd0,   // read miss, block wanted shared
      BOP_RDX = 2'd1,   // write miss, block wanted exclusive
      BOP_UPG = 2'd2,   // write to shared copy, invalidate others
      BOP_WB  = 2'd3    // dirty victim write-back
   } bus_op_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] last_q;
   logic [PW-1:0] gnt_idx;
   logic          found;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      for (int k = 1; k <= N; k++) begin
         if (!found && req[(int'(last_q) + k) % N]) begin
            gnt[(int'(last_q) + k) % N] = 1'b1;
            found = 1'b1;
         end
      end
   end

   always_comb begin
      gnt_idx = last_q;
      for (int i = 0; i < N; i++)
         if (gnt[i]) gnt_idx = PW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    last_q <= PW'(N - 1);
      else if (|gnt) last_q <= gnt_idx;
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R9
   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0); // R9
endmodule

// File: rtl/coh_mem.sv
module coh_mem
   import coh_pkg::*;
#(
   parameter int BLK_W = 5,
   parameter int WORDS = 2,
   parameter int DW    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  bus_op_e             bus_op,
   input  logic [BLK_W-1:0]    bus_blk,
   input  logic [WORDS*DW-1:0] mst_line,
   input  logic                own_any,
   input  logic [WORDS*DW-1:0] own_line,
   output logic [WORDS*DW-1:0] rline
);
   localparam int NBLK = 1 << BLK_W;

   logic [WORDS*DW-1:0] mem_q [NBLK];

   assign rline = own_any ? own_line : mem_q[bus_blk];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++)
            for (int w = 0; w < WORDS; w++)
               mem_q[b][w*DW +: DW] <= DW'((b*WORDS + w) ^ 'hA5);
      end else if (bus_valid) begin
         if (bus_op == BOP_WB)
            mem_q[bus_blk] <= mst_line;
         else if (own_any && (bus_op == BOP_RD || bus_op == BOP_RDX))
            mem_q[bus_blk] <= own_line;
      end
   end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
   import coh_pkg::*;
#(
   parameter int AW    = 6,
   parameter int DW    = 8,
   parameter int WORDS = 2,
   parameter int SETS  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_req,
   input  logic                       cpu_we,
   input  logic [AW-1:0]              cpu_addr,
   input  logic [DW-1:0]              cpu_wdata,
   output logic                       cpu_done,
   output logic                       cpu_hit,
   output logic [DW-1:0]              cpu_rdata,
   output logic                       bus_req,
   output bus_op_e                    mst_op,
   output logic [AW-$clog2(WORDS)-1:0] mst_blk,
   output logic [WORDS*DW-1:0]        mst_line,
   input  logic                       bus_gnt,
   input  logic                       bus_valid,
   input  bus_op_e                    bus_op,
   input  logic [AW-$clog2(WORDS)-1:0] bus_blk,
   input  logic [WORDS*DW-1:0]        bus_rline,
   output logic                       snp_own,
   output logic [WORDS*DW-1:0]        snp_line
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int BLK_W  = AW - OFF_W;
   localparam int TAG_W  = BLK_W - IDX_W;
   localparam int LINE_W = WORDS * DW;

   line_st_e          st_q  [SETS];
   logic [TAG_W-1:0]  tag_q [SETS];
   logic [LINE_W-1:0] dat_q [SETS];

   logic [IDX_W-1:0] idx, s_idx;
   logic [TAG_W-1:0] tag, s_tag;
   logic [OFF_W-1:0] wsel;
   line_st_e         cur_st;
   logic             tag_hit, present, local_ok, active, snoop, local_go, s_match;
   logic [LINE_W-1:0] wr_old, wr_line;

   assign idx     = cpu_addr[OFF_W +: IDX_W];
   assign tag     = cpu_addr[AW-1 -: TAG_W];
   assign wsel    = cpu_addr[OFF_W-1:0];
   assign cur_st  = st_q[idx];
   assign tag_hit = (tag_q[idx] == tag);
   assign present = tag_hit && (cur_st != LS_INV);
   assign local_ok = present && (!cpu_we || cur_st == LS_MOD);
   assign active  = cpu_req && !cpu_done;
   assign snoop   = bus_valid && !bus_gnt;
   // a local hit yields to any foreign bus transaction in the same cycle
   assign local_go = active && local_ok && !snoop;
   assign bus_req  = active && !local_ok;

   // operation chosen from the current line state every cycle, so a copy
   // lost to a snoop while waiting turns an upgrade into read-for-ownership
   always_comb begin
      if (!tag_hit && cur_st == LS_MOD) mst_op = BOP_WB;
      else if (!present)                mst_op = cpu_we ? BOP_RDX : BOP_RD;
      else                              mst_op = BOP_UPG;
   end
   assign mst_blk  = (mst_op == BOP_WB) ? {tag_q[idx], idx} : {tag, idx};
   assign mst_line = dat_q[idx];

   // word merge for writes: fill data for RDX, local data otherwise
   assign wr_old = (mst_op == BOP_RDX && bus_gnt) ? bus_rline : dat_q[idx];
   always_comb begin
      wr_line = wr_old;
      wr_line[int'(wsel)*DW +: DW] = cpu_wdata;
   end

   // snoop side
   assign s_idx   = bus_blk[IDX_W-1:0];
   assign s_tag   = bus_blk[BLK_W-1 -: TAG_W];
   assign s_match = snoop && (tag_q[s_idx] == s_tag) && (st_q[s_idx] != LS_INV);
   assign snp_own = s_match && (st_q[s_idx] == LS_MOD) &&
                    (bus_op == BOP_RD || bus_op == BOP_RDX);
   assign snp_line = dat_q[s_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_done  <= 1'b0;
         cpu_hit   <= 1'b0;
         cpu_rdata <= '0;
         for (int i = 0; i < SETS; i++) begin
            st_q[i]  <= LS_INV;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end
      end else begin
         cpu_done <= 1'b0;
         if (local_go) begin
            cpu_done  <= 1'b1;
            cpu_hit   <= 1'b1;
            cpu_rdata <= cpu_we ? cpu_wdata : dat_q[idx][int'(wsel)*DW +: DW];
            if (cpu_we) dat_q[idx] <= wr_line;
         end else if (bus_gnt) begin
            if (mst_op == BOP_WB) begin
               st_q[idx] <= LS_INV;
            end else begin
               cpu_done <= 1'b1;
               cpu_hit  <= 1'b0;
               tag_q[idx] <= tag;
               if (mst_op == BOP_RD) begin
                  dat_q[idx] <= bus_rline;
                  st_q[idx]  <= LS_SHR;
                  cpu_rdata  <= bus_rline[int'(wsel)*DW +: DW];
               end else begin
                  dat_q[idx] <= wr_line;
                  st_q[idx]  <= LS_MOD;
                  cpu_rdata  <= cpu_wdata;
               end
            end
         end
         if (s_match) begin
            if (bus_op == BOP_RD && st_q[s_idx] == LS_MOD)
               st_q[s_idx] <= LS_SHR;
            else if (bus_op == BOP_RDX || bus_op == BOP_UPG)
               st_q[s_idx] <= LS_INV;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpu_done |=> !cpu_done); // R10
   AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      (s_match && (bus_op == BOP_RDX || bus_op == BOP_UPG)) |=> (st_q[$past(s_idx)] == LS_INV)); // R6
   AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_hit) |-> !$past(bus_gnt)); // R2
endmodule

// File: rtl/coh_bus_sys.sv
module coh_bus_sys
   import coh_pkg::*;
#(
   parameter int NC    = 2,
   parameter int AW    = 6,
   parameter int DW    = 8,
   parameter int WORDS = 2,
   parameter int SETS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NC-1:0]    cpu_req,
   input  logic [NC-1:0]    cpu_we,
   input  logic [NC*AW-1:0] cpu_addr,
   input  logic [NC*DW-1:0] cpu_wdata,
   output logic [NC-1:0]    cpu_done,
   output logic [NC-1:0]    cpu_hit,
   output logic [NC*DW-1:0] cpu_rdata
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int BLK_W  = AW - OFF_W;
   localparam int LINE_W = WORDS * DW;

   if (NC < 2) begin : g_chk_nc
      $error("coh_bus_sys: NC must be at least 2");
   end
   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_chk_words
      $error("coh_bus_sys: WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_chk_sets
      $error("coh_bus_sys: SETS must be a power of two of at least 2");
   end
   if (AW <= OFF_W + IDX_W) begin : g_chk_aw
      $error("coh_bus_sys: AW leaves no tag bits");
   end

   logic [NC-1:0]     breq, gnt, own;
   bus_op_e           m_op   [NC];
   logic [BLK_W-1:0]  m_blk  [NC];
   logic [LINE_W-1:0] m_line [NC];
   logic [LINE_W-1:0] o_line [NC];

   logic              bus_valid, own_any;
   bus_op_e           bus_op;
   logic [BLK_W-1:0]  bus_blk;
   logic [LINE_W-1:0] bus_mline, own_line, bus_rline;

   coh_rr_arb #(.N(NC)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (breq),
      .gnt   (gnt)
   );

   always_comb begin
      bus_valid = |gnt;
      bus_op    = BOP_RD;
      bus_blk   = '0;
      bus_mline = '0;
      own_any   = |own;
      own_line  = '0;
      for (int i = 0; i < NC; i++) begin
         if (gnt[i]) begin
            bus_op    = m_op[i];
            bus_blk   = m_blk[i];
            bus_mline = m_line[i];
         end
         if (own[i]) own_line = o_line[i];
      end
   end

   for (genvar g = 0; g < NC; g++) begin : g_cache
      coh_ctrl #(.AW(AW), .DW(DW), .WORDS(WORDS), .SETS(SETS)) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .cpu_req   (cpu_req[g]),
         .cpu_we    (cpu_we[g]),
         .cpu_addr  (cpu_addr[g*AW +: AW]),
         .cpu_wdata (cpu_wdata[g*DW +: DW]),
         .cpu_done  (cpu_done[g]),
         .cpu_hit   (cpu_hit[g]),
         .cpu_rdata (cpu_rdata[g*DW +: DW]),
         .bus_req   (breq[g]),
         .mst_op    (m_op[g]),
         .mst_blk   (m_blk[g]),
         .mst_line  (m_line[g]),
         .bus_gnt   (gnt[g]),
         .bus_valid (bus_valid),
         .bus_op    (bus_op),
         .bus_blk   (bus_blk),
         .bus_rline (bus_rline),
         .snp_own   (own[g]),
         .snp_line  (o_line[g])
      );
   end

   coh_mem #(.BLK_W(BLK_W), .WORDS(WORDS), .DW(DW)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_op    (bus_op),
      .bus_blk   (bus_blk),
      .mst_line  (bus_mline),
      .own_any   (own_any),
      .own_line  (own_line),
      .rline     (bus_rline)
   );

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(own)); // R9
   AST_OWN_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n) own_any |-> bus_valid); // R3
endmodule

// File: tb/tb_coh_bus_sys.sv
`timescale 1ns/1ps
module tb_coh_bus_sys;
   localparam int NC = 2;
   localparam int AW = 6;
   localparam int DW = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NC-1:0]    cpu_req = '0;
   logic [NC-1:0]    cpu_we = '0;
   logic [NC*AW-1:0] cpu_addr = '0;
   logic [NC*DW-1:0] cpu_wdata = '0;
   logic [NC-1:0]    cpu_done;
   logic [NC-1:0]    cpu_hit;
   logic [NC*DW-1:0] cpu_rdata;

   always #2.5 clk = ~clk;

   coh_bus_sys #(.NC(NC), .AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata)
   );

   typedef struct {
      bit         chk_data;
      logic [7:0] data;
      bit         hit;
      string      tg;
   } exp_t;

   exp_t       q0[$];
   exp_t       q1[$];
   logic [7:0] ref_mem [64];
   int         errors = 0;
   int         checks = 0;
   int         cyc = 0;
   int         done_cyc [NC];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string tg, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
      end
   endtask

   // driver: pushes the expected result, then runs one request on cache c
   task automatic op(int c, bit we, logic [5:0] a, logic [7:0] d, bit exp_hit, string tg);
      exp_t e;
      e.chk_data = !we;
      e.data     = ref_mem[a];
      e.hit      = exp_hit;
      e.tg       = tg;
      if (we) ref_mem[a] = d;
      if (c == 0) q0.push_back(e); else q1.push_back(e);
      @(negedge clk);
      cpu_we[c] = we;
      cpu_addr[c*AW +: AW] = a;
      cpu_wdata[c*DW +: DW] = d;
      cpu_req[c] = 1'b1;
      do @(negedge clk); while (!cpu_done[c]);
      cpu_req[c] = 1'b0;
      done_cyc[c] = cyc;
      @(negedge clk);
      check(!cpu_done[c], "R10", "done not a single pulse", int'(cpu_done[c]), 0);
   endtask

   // monitor: pops and compares on every completion
   always @(negedge clk) begin
      for (int c = 0; c < NC; c++) begin
         if (rst_n && cpu_done[c]) begin
            exp_t e;
            if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
               check(1'b0, "R10", "unexpected done", c, 0);
            end else begin
               e = (c == 0) ? q0.pop_front() : q1.pop_front();
               check(cpu_hit[c] == e.hit, e.tg, "hit flag", int'(cpu_hit[c]), int'(e.hit));
               if (e.chk_data)
                  check(cpu_rdata[c*DW +: DW] == e.data, e.tg, "read data",
                        int'(cpu_rdata[c*DW +: DW]), int'(e.data));
            end
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int a = 0; a < 64; a++) ref_mem[a] = 8'(a) ^ 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cpu_done == '0, "R1", "done after reset", int'(cpu_done), 0);

      op(0, 0, 6'h04, 8'h00, 0, "R1");   // cold miss returns reset memory contents
      op(0, 0, 6'h05, 8'h00, 1, "R2");   // other word of same block: local hit
      op(1, 0, 6'h04, 8'h00, 0, "R3");   // second sharer
      op(1, 1, 6'h04, 8'h11, 0, "R4");   // upgrade on shared copy
      op(0, 0, 6'h05, 8'h00, 0, "R6");   // whole block was invalidated
      op(0, 0, 6'h04, 8'h00, 1, "R3");   // owner supplied, both shared
      op(1, 1, 6'h04, 8'h22, 0, "R4");
      op(1, 1, 6'h05, 8'h33, 1, "R5");   // modified: local write
      op(0, 1, 6'h05, 8'h44, 0, "R7");   // read-for-ownership from owner
      op(1, 0, 6'h04, 8'h00, 0, "R7");   // merged data visible
      op(0, 1, 6'h0C, 8'h55, 0, "R7");   // conflict miss, clean victim
      op(1, 0, 6'h0C, 8'h00, 0, "R3");
      op(0, 1, 6'h0D, 8'h66, 0, "R4");
      op(0, 0, 6'h04, 8'h00, 0, "R8");   // dirty victim written back first
      op(1, 0, 6'h0D, 8'h00, 0, "R8");   // value comes from memory

      // R9: round-robin order
      op(1, 0, 6'h20, 8'h00, 0, "R9");
      fork
         op(0, 0, 6'h30, 8'h00, 0, "R9");
         op(1, 0, 6'h12, 8'h00, 0, "R9");
      join
      check(done_cyc[0] < done_cyc[1], "R9", "cache0 should win after cache1", done_cyc[0], done_cyc[1]);
      op(0, 0, 6'h06, 8'h00, 0, "R9");
      fork
         op(0, 0, 6'h26, 8'h00, 0, "R9");
         op(1, 0, 6'h32, 8'h00, 0, "R9");
      join
      check(done_cyc[1] < done_cyc[0], "R9", "cache1 should win after cache0", done_cyc[1], done_cyc[0]);

      // R11: simultaneous writes to one shared block
      op(0, 0, 6'h18, 8'h00, 0, "R11");
      op(1, 0, 6'h18, 8'h00, 0, "R11");
      fork
         op(0, 1, 6'h18, 8'hA1, 0, "R11");
         op(1, 1, 6'h19, 8'hB2, 0, "R11");
      join
      op(0, 0, 6'h19, 8'h00, 0, "R11");
      op(1, 0, 6'h18, 8'h00, 1, "R11");

      repeat (3) @(negedge clk);
      check(q0.size() == 0 && q1.size() == 0, "R10", "missing completions",
            q0.size() + q1.size(), 0);
      summary();
   end
endmodule